// File: doc/BRIEF.md
# Parallel Systematic BCH Encoder

This block encodes a stream of messages with a binary BCH code, a fixed number of message bits per clock. Each message enters through a valid/ready sink whose first and last beats carry start and end markers. The message bits go straight through to a valid/ready source, in the order they arrived. The check bits follow as a burst of beats. They are the remainder of the message polynomial, multiplied by x^PAR_W, divided by the generator polynomial. A chain of DATA_W unrolled LFSR stages computes that remainder, so each accepted beat advances the division by DATA_W bits.

While the check bits are being sent, the sink is closed. The sink's ready drops on the final message beat, so the upstream source can stop at once. A downstream stall holds the parity burst, and while it lasts no further message beat is taken. Shortened codes need no special handling. Leading zero message bits leave the remainder unchanged, so a configuration with fewer message bits gives the parity of the full-length code with those bits set to zero.

The default configuration is a length-15 code with 7 message bits, 8 check bits, correcting 2 errors. Its generator is x^8+x^7+x^6+x^4+1. DATA_W must divide both K_LEN and PAR_W.

Top module: `bch_par_enc`

## Requirements
- R1: While rst_ni is low, out_valid_o and out_sop_o are low. Once reset is released, with no message in progress and out_ready_i high, in_ready_o is high.
- R2: Each codeword carries its K_LEN message bits unchanged, in input order, ahead of the check bits. Within a beat, bit DATA_W-1 is the earliest bit, on the way in and on the way out.
- R3: The PAR_W check bits equal the remainder of m(x)·x^PAR_W modulo GEN_POLY, most significant bit first. The complete codeword polynomial is divisible by GEN_POLY.
- R4: The source emits (K_LEN+PAR_W)/DATA_W beats per codeword. out_sop_o is high only on the first of these beats and out_eop_o only on the last. The final input beat, marked by in_eop_i, is the beat on which in_ready_o is low.
- R5: in_ready_o is low during the final message beat, and that beat is still taken when in_valid_i and out_ready_i are high. in_ready_o then stays low for the PAR_W/DATA_W cycles of the parity burst, provided out_ready_i stays high, and rises on the following cycle.
- R6: While out_ready_i is low, a parity beat keeps out_valid_o high and out_data_o stable. No input is taken, and in_ready_o is never high while out_ready_i is low.
- R7: With K_LEN shorter than the full message length of 7, the check bits equal those of the 7-bit message formed by putting zeros ahead of the shortened message.
- R8: Beats presented without in_sop_i while no message is in progress are consumed and dropped, with out_valid_o held low. Encoding starts at the next beat carrying in_sop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Sink ready; low on the final message beat and during parity |
| in_data_i | input | DATA_W | Message bits, bit DATA_W-1 earliest |
| in_sop_i | input | 1 | First beat of a message |
| in_eop_i | input | 1 | Last beat of a message |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | DATA_W | Codeword bits, bit DATA_W-1 earliest |
| out_sop_o | output | 1 | First beat of a codeword |
| out_eop_o | output | 1 | Last beat of a codeword |

## Verification
Some properties are checked on every cycle: the sink stays closed during the parity burst, ready never runs ahead of downstream readiness, and a stalled parity beat keeps its data. The output start and end flags are also checked every cycle against a count of accepted output beats. Some results can only come from the bench's scenarios. These are the check bits against a bit-serial division model, divisibility of the whole codeword, equality of shortened-code parity with the zero-padded full code, dropping of beats that arrive before a start marker, and the exact cycle on which ready rises after a burst. The bench runs two configurations: the default code at one bit per beat, and a shortened 4-bit-message code at two bits per beat.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAR  = 2'd2
  } enc_phase_e;
endpackage

// File: rtl/bch_lfsr_step.sv
// DATA_W unrolled steps of the remainder LFSR; bit DATA_W-1 enters first.
module bch_lfsr_step #(
  parameter int unsigned PAR_W = 8,
  parameter int unsigned DATA_W = 1,
  parameter logic [PAR_W-1:0] POLY_LO = '0
) (
  input  logic [PAR_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] bits_i,
  output logic [PAR_W-1:0]  rem_o
);
  logic [PAR_W-1:0] chain [DATA_W+1];

  assign chain[0] = rem_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic fb;
    assign fb = chain[i][PAR_W-1] ^ bits_i[DATA_W-1-i];
    assign chain[i+1] = {chain[i][PAR_W-2:0], 1'b0} ^ (fb ? POLY_LO : '0);
  end

  assign rem_o = chain[DATA_W];
endmodule

// File: rtl/bch_enc_ctrl.sv
module bch_enc_ctrl
  import bch_enc_pkg::*;
#(
  parameter int unsigned MSG_BEATS = 7,
  parameter int unsigned PAR_BEATS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic in_sop_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic out_sop_o,
  output logic out_eop_o,
  output logic lfsr_en_o,
  output logic lfsr_clr_o,
  output logic par_shift_o,
  output logic par_active_o
);
  localparam int unsigned MAX_BEATS = (MSG_BEATS > PAR_BEATS) ? MSG_BEATS : PAR_BEATS;
  localparam int unsigned CNT_W = $clog2(MAX_BEATS + 1);
  localparam logic [CNT_W-1:0] MSG_LAST = CNT_W'(MSG_BEATS - 1);
  localparam logic [CNT_W-1:0] PAR_LAST = CNT_W'(PAR_BEATS - 1);
  localparam bit SINGLE_BEAT = (MSG_BEATS == 1);

  enc_phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic is_idle, is_msg, is_par;
  logic starts, last_in, last_par, take_ok, beat_in;

  assign is_idle  = (phase_q == PH_IDLE);
  assign is_msg   = (phase_q == PH_MSG);
  assign is_par   = (phase_q == PH_PAR);
  assign starts   = is_idle && in_sop_i;
  assign last_in  = (is_msg && cnt_q == MSG_LAST) || (SINGLE_BEAT && starts);
  assign last_par = is_par && cnt_q == PAR_LAST;
  assign take_ok  = !is_par && out_ready_i;
  assign beat_in  = in_valid_i && take_ok;

  // ready drops one beat early; the final beat is still taken
  assign in_ready_o   = take_ok && !last_in;
  assign out_valid_o  = is_par || (in_valid_i && (is_msg || starts));
  assign out_sop_o    = in_valid_i && starts;
  assign out_eop_o    = last_par;
  assign lfsr_en_o    = beat_in && (is_msg || starts);
  assign lfsr_clr_o   = starts;
  assign par_shift_o  = is_par && out_ready_i;
  assign par_active_o = is_par;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (beat_in && in_sop_i) begin
        if (SINGLE_BEAT) begin
          phase_d = PH_PAR;
          cnt_d   = '0;
        end else begin
          phase_d = PH_MSG;
          cnt_d   = CNT_W'(1);
        end
      end
      PH_MSG: if (beat_in) begin
        if (last_in) begin
          phase_d = PH_PAR;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_PAR: if (out_ready_i) begin
        if (last_par) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bch_par_enc.sv
module bch_par_enc #(
  parameter int unsigned K_LEN = 7,
  parameter int unsigned PAR_W = 8,
  parameter int unsigned DATA_W = 1,
  parameter logic [PAR_W:0] GEN_POLY = 9'h1D1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  localparam int unsigned MSG_BEATS = K_LEN / DATA_W;
  localparam int unsigned PAR_BEATS = PAR_W / DATA_W;
  localparam logic [PAR_W-1:0] POLY_LO = GEN_POLY[PAR_W-1:0];

  logic lfsr_en, lfsr_clr, par_shift, par_active;
  logic [PAR_W-1:0] rem_q, rem_seed, rem_next;

  bch_enc_ctrl #(
    .MSG_BEATS(MSG_BEATS),
    .PAR_BEATS(PAR_BEATS)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_sop_i    (in_sop_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_sop_o   (out_sop_o),
    .out_eop_o   (out_eop_o),
    .lfsr_en_o   (lfsr_en),
    .lfsr_clr_o  (lfsr_clr),
    .par_shift_o (par_shift),
    .par_active_o(par_active)
  );

  assign rem_seed = lfsr_clr ? '0 : rem_q;

  bch_lfsr_step #(
    .PAR_W  (PAR_W),
    .DATA_W (DATA_W),
    .POLY_LO(POLY_LO)
  ) u_step (
    .rem_i (rem_seed),
    .bits_i(in_data_i),
    .rem_o (rem_next)
  );

  // remainder register doubles as the parity shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rem_q <= '0;
    else if (lfsr_en)   rem_q <= rem_next;
    else if (par_shift) rem_q <= rem_q << DATA_W;
  end

  assign out_data_o = par_active ? rem_q[PAR_W-1 -: DATA_W] : in_data_i;
endmodule

// File: rtl/bch_par_enc_chk.sv
module bch_par_enc_chk #(
  parameter int unsigned K_LEN = 7,
  parameter int unsigned PAR_W = 8,
  parameter int unsigned DATA_W = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_eop_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic              par_active_i
);
  localparam int unsigned TOT = (K_LEN + PAR_W) / DATA_W;
  localparam int unsigned OC_W = $clog2(TOT + 1);

  logic [OC_W-1:0] ocnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ocnt_q <= '0;
    else if (out_valid_o && out_ready_i) ocnt_q <= out_eop_o ? '0 : ocnt_q + OC_W'(1);
  end

  a_r4_sop_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sop_o |-> ocnt_q == '0);

  a_r4_eop_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_eop_o |-> ocnt_q == OC_W'(TOT - 1));

  a_r4_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sop_o || out_eop_o) |-> out_valid_o);

  a_r4_eop_in_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_eop_i && out_ready_i && !par_active_i |-> !in_ready_o);

  a_r5_closed_in_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_active_i |-> !in_ready_o && out_valid_o);

  a_r6_ready_follows_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> out_ready_i);

  a_r6_parity_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_active_i && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

bind bch_par_enc bch_par_enc_chk #(
  .K_LEN (K_LEN),
  .PAR_W (PAR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_eop_i    (in_eop_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .par_active_i(par_active)
);

// File: tb/bch_par_enc_bench.sv
module bch_enc_harness #(
  parameter int unsigned K_LEN = 7,
  parameter int unsigned DATA_W = 1,
  parameter int unsigned N_MSG = 60,
  parameter int unsigned SEED = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned PAR_W = 8;
  localparam int unsigned K_FULL = 7;
  localparam logic [8:0] GEN = 9'h1D1;
  localparam int unsigned MSG_BEATS = K_LEN / DATA_W;
  localparam int unsigned PAR_BEATS = PAR_W / DATA_W;
  localparam int unsigned TOT = MSG_BEATS + PAR_BEATS;
  localparam logic [6:0] MASK = 7'((1 << K_LEN) - 1);

  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              in_sop_i = 1'b0;
  logic              in_eop_i = 1'b0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic [DATA_W-1:0] out_data_o;
  logic              out_sop_o;
  logic              out_eop_o;

  int n_checks = 0;
  int n_errs = 0;
  bit rnd_ready = 1'b0;
  logic [6:0] exp_q[$];
  logic [14:0] cw_acc = '0;
  int obeat = 0;

  bch_par_enc #(
    .K_LEN (K_LEN),
    .PAR_W (PAR_W),
    .DATA_W(DATA_W)
  ) u_bch_par_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (in_data_i),
    .in_sop_i   (in_sop_i),
    .in_eop_i   (in_eop_i),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o),
    .out_sop_o  (out_sop_o),
    .out_eop_o  (out_eop_o)
  );

  function automatic logic [7:0] ref_parity(input logic [6:0] msg, input int len);
    logic [7:0] r;
    logic fb;
    r = '0;
    for (int i = len - 1; i >= 0; i--) begin
      fb = r[7] ^ msg[i];
      r = {r[6:0], 1'b0} ^ (fb ? GEN[7:0] : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] poly_mod(input logic [14:0] cw, input int len);
    logic [8:0] r;
    r = '0;
    for (int i = len - 1; i >= 0; i--) begin
      r = {r[7:0], cw[i]};
      if (r[8]) r = r ^ GEN;
    end
    return r[7:0];
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %m %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive_beat(input logic [DATA_W-1:0] d, input bit s, input bit e);
    in_valid_i = 1'b1;
    in_data_i = d;
    in_sop_i = s;
    in_eop_i = e;
    forever begin
      @(negedge clk_i);
      if (out_ready_i && (in_ready_o || e)) begin
        if (e) chk(in_ready_o == 1'b0, "R5 ready low on final beat", int'(in_ready_o), 0);
        break;
      end
    end
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
    in_sop_i = 1'b0;
    in_eop_i = 1'b0;
  endtask

  task automatic send_msg(input logic [6:0] m);
    exp_q.push_back(m);
    for (int b = 0; b < MSG_BEATS; b++)
      drive_beat(m[K_LEN - 1 - b * DATA_W -: DATA_W], b == 0, b == MSG_BEATS - 1);
  endtask

  // output monitor
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      logic [6:0] m;
      logic [7:0] p;
      chk(out_sop_o == (obeat == 0), "R4 sop on first beat only", int'(out_sop_o), int'(obeat == 0));
      chk(out_eop_o == (obeat == TOT - 1), "R4 eop on last beat only", int'(out_eop_o),
          int'(obeat == TOT - 1));
      cw_acc = (cw_acc << DATA_W) | 15'(out_data_o);
      if (obeat == TOT - 1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 codeword without message", int'(cw_acc), 0);
        end else begin
          m = exp_q.pop_front();
          p = ref_parity(m, K_LEN);
          chk(cw_acc[K_LEN+PAR_W-1:PAR_W] == m[K_LEN-1:0], "R2 message bits forwarded in order",
              int'(cw_acc[K_LEN+PAR_W-1:PAR_W]), int'(m[K_LEN-1:0]));
          chk(cw_acc[PAR_W-1:0] == p, "R3 parity bits", int'(cw_acc[PAR_W-1:0]), int'(p));
          chk(poly_mod(cw_acc, K_LEN + PAR_W) == 8'h00, "R3 codeword divisible by g",
              int'(poly_mod(cw_acc, K_LEN + PAR_W)), 0);
          if (K_LEN < K_FULL)
            chk(cw_acc[PAR_W-1:0] == ref_parity(m, K_FULL), "R7 shortened equals zero-padded full",
                int'(cw_acc[PAR_W-1:0]), int'(ref_parity(m, K_FULL)));
        end
        obeat = 0;
        cw_acc = '0;
      end else begin
        obeat++;
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rnd_ready) out_ready_i = ($urandom % 4) != 0;
  end

  initial begin
    logic [DATA_W-1:0] d0;
    logic [6:0] m;
    int g;
    done_o = 1'b0;
    void'($urandom(SEED));

    // R1: quiet in reset, ready afterwards
    @(negedge clk_i);
    chk(out_valid_o == 1'b0 && out_sop_o == 1'b0, "R1 outputs low in reset", int'(out_valid_o), 0);
    wait (rst_ni);
    @(posedge clk_i);
    #1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1 ready after reset", int'(in_ready_o), 1);
    @(posedge clk_i);
    #1;

    // R8: beats without a start marker are dropped
    for (int i = 0; i < 3; i++) begin
      in_valid_i = 1'b1;
      in_data_i = DATA_W'($urandom);
      in_sop_i = 1'b0;
      @(negedge clk_i);
      chk(out_valid_o == 1'b0, "R8 pre-start beat not forwarded", int'(out_valid_o), 0);
      chk(in_ready_o == 1'b1, "R8 pre-start beat consumed", int'(in_ready_o), 1);
      @(posedge clk_i);
      #1;
    end
    in_valid_i = 1'b0;
    send_msg(7'h5A & MASK);

    // R5: ready stays low for the whole parity burst, then rises
    send_msg(7'h33 & MASK);
    for (int i = 0; i < PAR_BEATS; i++) begin
      @(negedge clk_i);
      chk(in_ready_o == 1'b0 && out_valid_o == 1'b1, "R5 input closed during parity",
          int'(in_ready_o), 0);
    end
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R5 ready rises after parity", int'(in_ready_o), 1);
    @(posedge clk_i);
    #1;

    // R6: stall in the middle of parity
    send_msg(7'h6D & MASK);
    out_ready_i = 1'b0;
    @(negedge clk_i);
    d0 = out_data_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(out_valid_o == 1'b1 && out_data_o == d0, "R6 parity held under stall",
          int'(out_data_o), int'(d0));
      chk(in_ready_o == 1'b0, "R6 no input under stall", int'(in_ready_o), 0);
    end
    @(posedge clk_i);
    #1;
    out_ready_i = 1'b1;

    // corner messages
    send_msg(7'h00);
    send_msg(MASK);
    send_msg(7'h01);

    // random traffic with random backpressure
    rnd_ready = 1'b1;
    for (int n = 0; n < N_MSG; n++) begin
      m = 7'($urandom) & MASK;
      send_msg(m);
      g = $urandom % 3;
      repeat (g) begin
        @(posedge clk_i);
        #1;
      end
    end
    wait (exp_q.size() == 0);
    rnd_ready = 1'b0;
    repeat (2) @(posedge clk_i);
    done_o = 1'b1;
  end
endmodule

module bch_par_enc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_full, done_short;

  always #2 clk = ~clk;

  bch_enc_harness #(.K_LEN(7), .DATA_W(1), .N_MSG(60), .SEED(11)) u_full (
    .clk_i (clk),
    .rst_ni(rst_n),
    .done_o(done_full)
  );

  bch_enc_harness #(.K_LEN(4), .DATA_W(2), .N_MSG(60), .SEED(23)) u_short (
    .clk_i (clk),
    .rst_ni(rst_n),
    .done_o(done_short)
  );

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
  end

  initial begin
    int cyc;
    int checks;
    int errs;
    cyc = 0;
    while (!(done_full === 1'b1 && done_short === 1'b1) && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    checks = u_full.n_checks + u_short.n_checks;
    errs = u_full.n_errs + u_short.n_errs;
    if (cyc >= 50000) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule